// File: doc/BRIEF.md
# Timer Channel Status Flags

This block keeps the sticky event flags of one channel of a 16-bit general-purpose timer. The counter, its phase-counting decode and the general registers live elsewhere; they reach this block only as single-cycle event pulses: counter wrap upward, counter wrap downward, compare match, and capture load. Each pulse sets a flag that stays at 1 until it is cleared on purpose.

Software clears a flag in two steps. It reads the status register and sees the flag at 1, then writes 0 to that bit. A write of 0 that has no such read before it does nothing. The capture/compare flag can also be cleared by the DMA controller. This happens when a transfer starts in response to that flag's request and the controller has been told to use this channel's capture/compare interrupt as its trigger. Every flag drives an interrupt request through its own enable bit. The capture/compare request also feeds the DMA controller.

The parameter `CHAN_KIND` selects the channel type. Kind 0 has the capture/compare D flag and no underflow flag. Kind 1 has the underflow flag and no D flag. A flag that is missing on the selected kind is reserved: it always reads 0 and cannot be written.

Top module: `tmr_chan_status`

## Requirements
- R1: After reset, `rd_data`, `irq` and `dma_req` are all 0.
- R2: A pulse on `cnt_ovf_evt` makes the overflow flag (`rd_data[0]`) read 1 from the next cycle on, on both channel kinds.
- R3: On kind 1, a pulse on `cnt_unf_evt` sets the underflow flag (`rd_data[1]`) only while `phase_mode` is 1. When `phase_mode` is 0, the pulse is ignored.
- R4: On kind 0, the D flag (`rd_data[2]`) sets on `cmp_match_evt` while `ccd_is_capture` is 0 (compare mode). It sets on `cap_load_evt` while `ccd_is_capture` is 1 (capture mode). The event that belongs to the other mode is ignored.
- R5: Writing 0 to a flag bit clears that flag only if a read (`rd_en`) returned that flag as 1 after the most recent write. A 0 written without such a read leaves the flag set. Any write, whatever its data, cancels all pending reads.
- R6: Writing 1 to a flag bit has no effect. It neither sets a clear flag nor clears a set one.
- R7: If a set event and a valid software clear of the same flag arrive in the same cycle, the flag stays 1.
- R8: When `dma_ack` and `dma_sel_ccd` are both 1, the D flag is cleared. When `dma_ack` is 1 and `dma_sel_ccd` is 0, the D flag is unchanged.
- R9: Reserved flags always read 0: bit 1 on kind 0 and bit 2 on kind 1. Events and writes do not change this.
- R10: `irq[i]` equals flag i AND `irq_en[i]`. `dma_req` equals `irq[2]` AND `dma_sel_ccd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_mode | input | 1 | Channel is in phase counting mode |
| cnt_ovf_evt | input | 1 | Counter wrapped from 0xFFFF to 0x0000 |
| cnt_unf_evt | input | 1 | Counter wrapped from 0x0000 to 0xFFFF |
| ccd_is_capture | input | 1 | Register D mode: 1 input capture, 0 output compare |
| cmp_match_evt | input | 1 | Counter equals register D |
| cap_load_evt | input | 1 | Capture edge loaded the counter into register D |
| dma_sel_ccd | input | 1 | DMA controller triggers on this D interrupt |
| dma_ack | input | 1 | DMA transfer started for the D request |
| rd_en | input | 1 | Status register read strobe |
| wr_en | input | 1 | Status register write strobe |
| wr_data | input | 3 | Write data: bit 0 overflow, bit 1 underflow, bit 2 D flag |
| irq_en | input | 3 | Per-flag interrupt enables, same bit layout |
| rd_data | output | 3 | Status register value, same bit layout |
| irq | output | 3 | Per-flag interrupt requests |
| dma_req | output | 1 | DMA request from the D flag |

## Verification
Some rules can be checked on every cycle from the ports alone, so the assertions cover them. An event always leaves its flag at 1 on the next cycle, even when a clear arrives in the same cycle. Without an event, a clear flag stays clear whatever is written to it. Underflow cannot set outside phase mode. A qualified DMA acknowledge empties the D flag. Reserved bits stay 0, and the request outputs never fire without their enable. The read-then-write handshake depends on what happened several accesses earlier, so only the bench scenarios can show it. These include the rejected clear with no read, a write of 1 that cancels a pending read, and a read and write in the same cycle as a set event.

// File: rtl/tmr_stat_pkg.sv
package tmr_stat_pkg;
  localparam int NFLAG   = 3;
  localparam int IDX_OVF = 0;
  localparam int IDX_UNF = 1;
  localparam int IDX_CCD = 2;

  // channel kind 0: D flag present, no underflow; kind 1: underflow, no D flag
  function automatic logic kind_has_unf(input int kind);
    return (kind == 1);
  endfunction

  function automatic logic kind_has_ccd(input int kind);
    return (kind == 0);
  endfunction
endpackage

// File: rtl/tmr_stat_evt.sv
module tmr_stat_evt
  import tmr_stat_pkg::*;
(
  input  logic             phase_mode,
  input  logic             cnt_ovf_evt,
  input  logic             cnt_unf_evt,
  input  logic             ccd_is_capture,
  input  logic             cmp_match_evt,
  input  logic             cap_load_evt,
  input  logic             dma_sel_ccd,
  input  logic             dma_ack,
  output logic [NFLAG-1:0] set_vec,
  output logic [NFLAG-1:0] hw_clr_vec
);
  always_comb begin
    set_vec             = '0;
    set_vec[IDX_OVF]    = cnt_ovf_evt;
    set_vec[IDX_UNF]    = cnt_unf_evt & phase_mode;
    set_vec[IDX_CCD]    = ccd_is_capture ? cap_load_evt : cmp_match_evt;
    hw_clr_vec          = '0;
    hw_clr_vec[IDX_CCD] = dma_ack & dma_sel_ccd;
  end
endmodule

// File: rtl/tmr_stat_flag.sv
module tmr_stat_flag #(
  parameter bit IMPL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic hw_clr,
  input  logic rd_stb,
  input  logic wr_stb,
  input  logic wr_bit,
  output logic flag_q,
  output logic seen_q
);
  generate
    if (IMPL) begin : g_impl
      logic flag_d, seen_d, upd_en;

      always_comb begin
        upd_en = set_evt | hw_clr | rd_stb | wr_stb;
        flag_d = flag_q;
        if (wr_stb && !wr_bit && seen_q) flag_d = 1'b0;
        if (hw_clr)                      flag_d = 1'b0;
        if (set_evt)                     flag_d = 1'b1;
        seen_d = seen_q;
        if (rd_stb && flag_q) seen_d = 1'b1;
        if (wr_stb)           seen_d = 1'b0;
        if (!flag_d)          seen_d = 1'b0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          flag_q <= 1'b0;
          seen_q <= 1'b0;
        end else if (upd_en) begin
          flag_q <= flag_d;
          seen_q <= seen_d;
        end
      end
    end else begin : g_rsvd
      assign flag_q = 1'b0;
      assign seen_q = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/tmr_chan_status.sv
module tmr_chan_status
  import tmr_stat_pkg::*;
#(
  parameter int CHAN_KIND = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             phase_mode,
  input  logic             cnt_ovf_evt,
  input  logic             cnt_unf_evt,
  input  logic             ccd_is_capture,
  input  logic             cmp_match_evt,
  input  logic             cap_load_evt,
  input  logic             dma_sel_ccd,
  input  logic             dma_ack,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [NFLAG-1:0] wr_data,
  input  logic [NFLAG-1:0] irq_en,
  output logic [NFLAG-1:0] rd_data,
  output logic [NFLAG-1:0] irq,
  output logic             dma_req
);
  localparam bit HAS_UNF = kind_has_unf(CHAN_KIND);
  localparam bit HAS_CCD = kind_has_ccd(CHAN_KIND);
  localparam logic [NFLAG-1:0] IMPL_MASK =
    {HAS_CCD, HAS_UNF, 1'b1};

  logic [NFLAG-1:0] set_vec, hw_clr_vec, flags, seen;

  tmr_stat_evt u_evt (
    .phase_mode     (phase_mode),
    .cnt_ovf_evt    (cnt_ovf_evt),
    .cnt_unf_evt    (cnt_unf_evt),
    .ccd_is_capture (ccd_is_capture),
    .cmp_match_evt  (cmp_match_evt),
    .cap_load_evt   (cap_load_evt),
    .dma_sel_ccd    (dma_sel_ccd),
    .dma_ack        (dma_ack),
    .set_vec        (set_vec),
    .hw_clr_vec     (hw_clr_vec)
  );

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    tmr_stat_flag #(.IMPL(IMPL_MASK[i])) u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_evt (set_vec[i]),
      .hw_clr  (hw_clr_vec[i]),
      .rd_stb  (rd_en),
      .wr_stb  (wr_en),
      .wr_bit  (wr_data[i]),
      .flag_q  (flags[i]),
      .seen_q  (seen[i])
    );
  end

  logic unused_seen;
  assign unused_seen = ^seen;

  assign rd_data = flags;
  assign irq     = flags & irq_en;
  assign dma_req = irq[IDX_CCD] & dma_sel_ccd;
endmodule

// File: rtl/tmr_chan_status_chk.sv
module tmr_chan_status_chk
  import tmr_stat_pkg::*;
#(
  parameter int CHAN_KIND = 0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             phase_mode,
  input logic             cnt_ovf_evt,
  input logic             cnt_unf_evt,
  input logic             ccd_is_capture,
  input logic             cmp_match_evt,
  input logic             cap_load_evt,
  input logic             dma_sel_ccd,
  input logic             dma_ack,
  input logic             rd_en,
  input logic             wr_en,
  input logic [NFLAG-1:0] wr_data,
  input logic [NFLAG-1:0] irq_en,
  input logic [NFLAG-1:0] rd_data,
  input logic [NFLAG-1:0] irq,
  input logic             dma_req
);
  localparam bit HAS_UNF = kind_has_unf(CHAN_KIND);
  localparam bit HAS_CCD = kind_has_ccd(CHAN_KIND);

  AST_OVF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_ovf_evt |=> rd_data[IDX_OVF]); // R2 R7
  AST_OVF_NO_SELF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data[IDX_OVF] && !cnt_ovf_evt) |=> !rd_data[IDX_OVF]); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[IDX_OVF] && !wr_en) |=> rd_data[IDX_OVF]); // R5
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (irq & ~(irq_en & rd_data)) == '0); // R10
  AST_DMA_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> (dma_sel_ccd && irq[IDX_CCD])); // R10

  generate
    if (HAS_UNF) begin : g_unf
      AST_UNF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_unf_evt && phase_mode) |=> rd_data[IDX_UNF]); // R3
      AST_UNF_NEEDS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!phase_mode && !rd_data[IDX_UNF]) |=> !rd_data[IDX_UNF]); // R3
    end else begin : g_unf_rsvd
      AST_UNF_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[IDX_UNF]); // R9
    end
    if (HAS_CCD) begin : g_ccd
      AST_CCD_CMP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ccd_is_capture && cmp_match_evt) |=> rd_data[IDX_CCD]); // R4
      AST_CCD_CAP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (ccd_is_capture && cap_load_evt) |=> rd_data[IDX_CCD]); // R4
      AST_CCD_DMA_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_ack && dma_sel_ccd && !cmp_match_evt && !cap_load_evt)
          |=> !rd_data[IDX_CCD]); // R8
    end else begin : g_ccd_rsvd
      AST_CCD_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[IDX_CCD]); // R9
    end
  endgenerate
endmodule

bind tmr_chan_status tmr_chan_status_chk #(.CHAN_KIND(CHAN_KIND)) u_chk (.*);

// File: tb/sim_tmr_chan_status.sv
`timescale 1ns/1ps
module sim_tmr_chan_status;
  logic clk = 1'b0;
  logic rst_n;
  logic phase_mode, cnt_ovf_evt, cnt_unf_evt, ccd_is_capture;
  logic cmp_match_evt, cap_load_evt, dma_sel_ccd, dma_ack;
  logic rd_en, wr_en;
  logic [2:0] wr_data, irq_en;
  logic [2:0] rd0, irq0, rd1, irq1;
  logic dreq0, dreq1;
  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tmr_chan_status #(.CHAN_KIND(0)) u0 (
    .clk(clk), .rst_n(rst_n), .phase_mode(phase_mode), .cnt_ovf_evt(cnt_ovf_evt),
    .cnt_unf_evt(cnt_unf_evt), .ccd_is_capture(ccd_is_capture),
    .cmp_match_evt(cmp_match_evt), .cap_load_evt(cap_load_evt),
    .dma_sel_ccd(dma_sel_ccd), .dma_ack(dma_ack), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .irq_en(irq_en), .rd_data(rd0), .irq(irq0), .dma_req(dreq0));

  tmr_chan_status #(.CHAN_KIND(1)) u1 (
    .clk(clk), .rst_n(rst_n), .phase_mode(phase_mode), .cnt_ovf_evt(cnt_ovf_evt),
    .cnt_unf_evt(cnt_unf_evt), .ccd_is_capture(ccd_is_capture),
    .cmp_match_evt(cmp_match_evt), .cap_load_evt(cap_load_evt),
    .dma_sel_ccd(dma_sel_ccd), .dma_ack(dma_ack), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .irq_en(irq_en), .rd_data(rd1), .irq(irq1), .dma_req(dreq1));

  task automatic chk(input string tag, input int got, input int exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic quiet();
    cnt_ovf_evt = 0; cnt_unf_evt = 0; cmp_match_evt = 0; cap_load_evt = 0;
    dma_ack = 0; rd_en = 0; wr_en = 0; wr_data = 3'b000;
  endtask

  task automatic do_read();
    rd_en = 1; step(); rd_en = 0;
  endtask

  task automatic do_write(input logic [2:0] d);
    wr_en = 1; wr_data = d; step(); wr_en = 0; wr_data = 3'b000;
  endtask

  task automatic clear_all();
    do_read(); do_write(3'b000);
  endtask

  task automatic t_reset();
    rst_n = 0; quiet(); phase_mode = 0; ccd_is_capture = 0; dma_sel_ccd = 0;
    irq_en = 3'b111;
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    chk("R1 rd_data kind0", rd0, 0);
    chk("R1 rd_data kind1", rd1, 0);
    chk("R1 irq", {irq0, irq1}, 0);
    chk("R1 dma_req", {dreq0, dreq1}, 0);
    irq_en = 3'b000;
  endtask

  task automatic t_overflow();
    cnt_ovf_evt = 1; step(); cnt_ovf_evt = 0;
    chk("R2 ovf kind0", rd0, 3'b001);
    chk("R2 ovf kind1", rd1, 3'b001);
    clear_all();
    chk("R5 cleared after handshake", rd0, 0);
  endtask

  task automatic t_underflow();
    phase_mode = 0; cnt_unf_evt = 1; step(); cnt_unf_evt = 0;
    chk("R3 unf ignored outside phase mode", rd1, 0);
    phase_mode = 1; cnt_unf_evt = 1; step(); cnt_unf_evt = 0;
    chk("R3 unf sets in phase mode", rd1, 3'b010);
    chk("R9 unf reserved on kind0", rd0, 0);
    do_read(); do_write(3'b111);
    chk("R9 unf still reserved after write", rd0, 0);
    clear_all();
    chk("R3 unf cleared", rd1, 0);
    phase_mode = 0;
  endtask

  task automatic t_ccd();
    ccd_is_capture = 0;
    cap_load_evt = 1; step(); cap_load_evt = 0;
    chk("R4 capture ignored in compare mode", rd0, 0);
    cmp_match_evt = 1; step(); cmp_match_evt = 0;
    chk("R4 compare sets D", rd0, 3'b100);
    chk("R9 D reserved on kind1", rd1, 0);
    clear_all();
    ccd_is_capture = 1;
    cmp_match_evt = 1; step(); cmp_match_evt = 0;
    chk("R4 compare ignored in capture mode", rd0, 0);
    cap_load_evt = 1; step(); cap_load_evt = 0;
    chk("R4 capture sets D", rd0, 3'b100);
    chk("R9 D reserved on kind1 capture", rd1, 0);
    clear_all();
    chk("R4 D cleared", rd0, 0);
    ccd_is_capture = 0;
  endtask

  task automatic t_handshake();
    cnt_ovf_evt = 1; step(); cnt_ovf_evt = 0;
    do_write(3'b000);
    chk("R5 write0 without read keeps flag", rd0, 3'b001);
    do_read(); do_write(3'b001); do_write(3'b000);
    chk("R5 intervening write cancels read", rd0, 3'b001);
    do_read(); do_write(3'b000);
    chk("R5 read then write0 clears", rd0, 0);
  endtask

  task automatic t_write_one();
    do_read(); do_write(3'b111);
    chk("R6 write1 does not set kind0", rd0, 0);
    chk("R6 write1 does not set kind1", rd1, 0);
    cnt_ovf_evt = 1; step(); cnt_ovf_evt = 0;
    do_read(); do_write(3'b001);
    chk("R6 write1 does not clear", rd0, 3'b001);
    clear_all();
  endtask

  task automatic t_set_wins();
    cnt_ovf_evt = 1; step(); cnt_ovf_evt = 0;
    do_read();
    cnt_ovf_evt = 1; wr_en = 1; wr_data = 3'b000; step();
    cnt_ovf_evt = 0; wr_en = 0;
    chk("R7 set wins over clear", rd0, 3'b001);
    clear_all();
    chk("R7 clean after", rd0, 0);
  endtask

  task automatic t_dma();
    cmp_match_evt = 1; step(); cmp_match_evt = 0;
    dma_sel_ccd = 0; dma_ack = 1; step(); dma_ack = 0;
    chk("R8 ack without select ignored", rd0, 3'b100);
    dma_sel_ccd = 1; dma_ack = 1; step(); dma_ack = 0;
    chk("R8 ack with select clears D", rd0, 0);
    dma_sel_ccd = 0;
  endtask

  task automatic t_irq();
    irq_en = 3'b000;
    cnt_ovf_evt = 1; cmp_match_evt = 1; step();
    cnt_ovf_evt = 0; cmp_match_evt = 0;
    chk("R10 irq masked", irq0, 0);
    irq_en = 3'b001; #1;
    chk("R10 ovf irq enabled", irq0, 3'b001);
    irq_en = 3'b100; dma_sel_ccd = 0; #1;
    chk("R10 D irq enabled", irq0, 3'b100);
    chk("R10 dma_req needs select", dreq0, 0);
    dma_sel_ccd = 1; #1;
    chk("R10 dma_req asserted", dreq0, 1);
    chk("R10 dma_req absent kind1", dreq1, 0);
    dma_sel_ccd = 0; irq_en = 3'b000;
    clear_all();
    chk("R10 cleared", rd0, 0);
  endtask

  initial begin
    t_reset();
    t_overflow();
    t_underflow();
    t_ccd();
    t_handshake();
    t_write_one();
    t_set_wins();
    t_dma();
    t_irq();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule